// File: doc/BRIEF.md
# Dynamic Shift and Rotate Unit

This block is the shift and rotate execution unit of a small RISC integer pipeline. Each operation takes a 32-bit operand, a shift control word supplied from a register, a 4-bit operation code and the current T flag. It returns a 32-bit result and a new T flag.

The register-controlled shifts take both the direction and the distance from one signed control word. When the sign bit is clear, the unit shifts left by the low five bits. When the sign bit is set, the unit shifts right by the two's-complement negation of those five bits, so a low field of zero with the sign set means a full-width right shift. The unit also carries the single-bit shifts, the rotates around T, the rotates through T, and fixed logical shifts by 2, 8 and 16.

The datapath is combinational. A parameter can add an output register with a synchronous active-high reset; by default that register is present.

Top module: `shrot_core`

## Requirements
- R1: The operation code on `op_i` selects the function as follows: 0 arithmetic dynamic shift, 1 logical dynamic shift, 2 rotate left, 3 rotate right, 4 rotate left through T, 5 rotate right through T, 6 arithmetic left by one, 7 arithmetic right by one, 8 logical left by one, 9 logical right by one, 10/11 logical left/right by 2, 12/13 logical left/right by 8, 14/15 logical left/right by 16.
- R2: For codes 0 and 1 with `ctrl_i[31]` = 0, the result is the operand shifted left by `ctrl_i[4:0]`, and the vacated bits are zero.
- R3: For codes 0 and 1 with `ctrl_i[31]` = 1 and `ctrl_i[4:0]` nonzero, the result is the operand shifted right by 32 − `ctrl_i[4:0]` positions. Code 0 fills with the operand's bit 31 and code 1 fills with zeros.
- R4: For codes 0 and 1 with `ctrl_i[31]` = 1 and `ctrl_i[4:0]` = 0, code 0 gives bit 31 copied into all 32 result bits and code 1 gives zero.
- R5: Rotate left (code 2) sends the operand's bit 31 to both T and result bit 0. Rotate right (code 3) sends bit 0 to both T and result bit 31.
- R6: Rotate left through T (code 4) puts the incoming T in result bit 0 and the operand's bit 31 in T. Rotate right through T (code 5) puts the incoming T in result bit 31 and the operand's bit 0 in T.
- R7: The one-position left shifts (codes 6 and 8) set T to the operand's bit 31. The one-position right shifts set T to the operand's bit 0; code 7 keeps bit 31 as it was and code 9 inserts a zero.
- R8: Codes 10 to 15 shift the operand by their fixed distance, with zeros filling the vacated bits.
- R9: Codes 0, 1 and 10 to 15 pass `t_i` to `t_o` unchanged. `ctrl_i` bits 30:5 have no effect on any result.
- R10: With the output register present (the default), the result and T appear one clock after the inputs are applied. While `rst` is high, both outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| operand_i | input | 32 | Value to shift or rotate |
| ctrl_i | input | 32 | Signed shift control word for the dynamic shifts |
| t_i | input | 1 | Current T flag |
| result_o | output | 32 | Shifted or rotated value |
| t_o | output | 1 | New T flag |

## Verification
The corner that is hardest to reach is a sign-set control word whose low five bits are all zero. This is the only code that turns into a 32-position right shift, and the only dynamic-shift case that leaves no room for the operand to survive. Random control words seldom land on it. The bench therefore walks all 64 combinations of the sign bit and the five-bit field, for both dynamic variants, so this code is always hit. It fills bits 30:5 of each control word with random data and alternates the operand's sign, which exposes sign-fill and direction errors as well as any dependence on the ignored bits.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int DW = 32;
    localparam int AW = $clog2(DW);
    localparam int NFIX = 3;

    typedef enum logic [3:0] {
        OP_DSHA   = 4'd0,
        OP_DSHL   = 4'd1,
        OP_ROTL   = 4'd2,
        OP_ROTR   = 4'd3,
        OP_ROTCL  = 4'd4,
        OP_ROTCR  = 4'd5,
        OP_SHAL   = 4'd6,
        OP_SHAR   = 4'd7,
        OP_SHLL   = 4'd8,
        OP_SHLR   = 4'd9,
        OP_SHLL2  = 4'd10,
        OP_SHLR2  = 4'd11,
        OP_SHLL8  = 4'd12,
        OP_SHLR8  = 4'd13,
        OP_SHLL16 = 4'd14,
        OP_SHLR16 = 4'd15
    } shop_e;

    typedef struct packed {
        logic [DW-1:0] value;
        logic          tflag;
    } shres_t;

    // Distance of fixed-shift slot k
    function automatic int fixed_amt(input int k);
        return (k == 0) ? 2 : ((k == 1) ? 8 : 16);
    endfunction

    function automatic logic is_dynamic(input shop_e op);
        return (op == OP_DSHA) || (op == OP_DSHL);
    endfunction

endpackage

// File: rtl/shrot_dyn.sv
module shrot_dyn
    import shrot_pkg::*;
(
    input  logic [DW-1:0] opnd,
    input  logic          neg,
    input  logic [AW-1:0] amt,
    input  logic          arith,
    output logic [DW-1:0] res
);
    // Right distance is the negated amount field (nonzero when amt != 0)
    logic [AW-1:0] ramt;
    assign ramt = ~amt + AW'(1);

    always_comb begin
        if (!neg) begin
            res = opnd << amt;
        end else if (amt == '0) begin
            res = arith ? {DW{opnd[DW-1]}} : '0;
        end else if (arith) begin
            res = DW'($signed(opnd) >>> ramt);
        end else begin
            res = opnd >> ramt;
        end
    end
endmodule

// File: rtl/shrot_bit.sv
module shrot_bit
    import shrot_pkg::*;
(
    input  shop_e         op,
    input  logic [DW-1:0] opnd,
    input  logic          t_in,
    output shres_t        res
);
    logic [DW-1:0] fix_l [NFIX];
    logic [DW-1:0] fix_r [NFIX];

    for (genvar k = 0; k < NFIX; k++) begin : g_fix
        assign fix_l[k] = opnd << fixed_amt(k);
        assign fix_r[k] = opnd >> fixed_amt(k);
    end

    logic [1:0] fsel;
    assign fsel = 2'(({1'b0, op[3:1]} - 4'd5));

    always_comb begin
        res.value = opnd;
        res.tflag = t_in;
        unique case (op)
            OP_ROTL:  begin res.value = {opnd[DW-2:0], opnd[DW-1]}; res.tflag = opnd[DW-1]; end
            OP_ROTR:  begin res.value = {opnd[0], opnd[DW-1:1]};    res.tflag = opnd[0];    end
            OP_ROTCL: begin res.value = {opnd[DW-2:0], t_in};       res.tflag = opnd[DW-1]; end
            OP_ROTCR: begin res.value = {t_in, opnd[DW-1:1]};       res.tflag = opnd[0];    end
            OP_SHAL, OP_SHLL: begin
                res.value = {opnd[DW-2:0], 1'b0};
                res.tflag = opnd[DW-1];
            end
            OP_SHAR:  begin res.value = {opnd[DW-1], opnd[DW-1:1]}; res.tflag = opnd[0]; end
            OP_SHLR:  begin res.value = {1'b0, opnd[DW-1:1]};       res.tflag = opnd[0]; end
            OP_SHLL2, OP_SHLR2, OP_SHLL8, OP_SHLR8, OP_SHLL16, OP_SHLR16: begin
                res.value = op[0] ? fix_r[fsel] : fix_l[fsel];
            end
            default: begin
                res.value = opnd;
                res.tflag = t_in;
            end
        endcase
    end
endmodule

// File: rtl/shrot_outreg.sv
module shrot_outreg
    import shrot_pkg::*;
#(
    parameter bit REG = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  shres_t d,
    output shres_t q
);
    if (REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_pass
        assign q = d;
    end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] operand_i,
    input  logic [DW-1:0] ctrl_i,
    input  logic          t_i,
    output logic [DW-1:0] result_o,
    output logic          t_o
);
    shop_e         op;
    logic [DW-1:0] dyn_val;
    shres_t        bit_res;
    shres_t        sel_res;
    shres_t        out_res;
    logic          unused_ctrl;

    assign op          = shop_e'(op_i);
    assign unused_ctrl = ^ctrl_i[DW-2:AW];

    shrot_dyn u_dyn (
        .opnd  (operand_i),
        .neg   (ctrl_i[DW-1]),
        .amt   (ctrl_i[AW-1:0]),
        .arith (op == OP_DSHA),
        .res   (dyn_val)
    );

    shrot_bit u_bit (
        .op   (op),
        .opnd (operand_i),
        .t_in (t_i),
        .res  (bit_res)
    );

    always_comb begin
        if (is_dynamic(op)) begin
            sel_res.value = dyn_val;
            sel_res.tflag = t_i;
        end else begin
            sel_res = bit_res;
        end
    end

    shrot_outreg #(.REG(REG_OUT)) u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (sel_res),
        .q   (out_res)
    );

    assign result_o = out_res.value;
    assign t_o      = out_res.tflag;
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk
    import shrot_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    op_i,
    input logic [DW-1:0] operand_i,
    input logic [DW-1:0] ctrl_i,
    input logic          t_i,
    input logic [DW-1:0] result_o,
    input logic          t_o
);
    if (REG_OUT) begin : g_lat1
        // R2
        dyn_left_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(op_i) <= 4'd1 && !$past(ctrl_i[DW-1]))
            |-> result_o == ($past(operand_i) << $past(ctrl_i[AW-1:0])));
        // R4
        full_right_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(op_i) <= 4'd1 && $past(ctrl_i[DW-1]) && $past(ctrl_i[AW-1:0]) == '0)
            |-> result_o == (($past(op_i) == 4'd0) ? {DW{$past(operand_i[DW-1])}} : '0));
        // R5
        rotl_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(op_i) == 4'd2)
            |-> (t_o == $past(operand_i[DW-1]) && result_o[0] == $past(operand_i[DW-1])));
        // R6
        rotcl_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(op_i) == 4'd4)
            |-> (result_o[0] == $past(t_i) && t_o == $past(operand_i[DW-1])));
        // R9
        t_keep_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && ($past(op_i) <= 4'd1 || $past(op_i) >= 4'd10))
            |-> t_o == $past(t_i));
        // R10
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) |-> (result_o == '0 && !t_o));
    end else begin : g_lat0
        // R2
        dyn_left_chk: assert property (@(posedge clk) disable iff (rst)
            (op_i <= 4'd1 && !ctrl_i[DW-1]) |-> result_o == (operand_i << ctrl_i[AW-1:0]));
        // R5
        rotl_chk: assert property (@(posedge clk) disable iff (rst)
            (op_i == 4'd2) |-> (t_o == operand_i[DW-1] && result_o[0] == operand_i[DW-1]));
        // R6
        rotcl_chk: assert property (@(posedge clk) disable iff (rst)
            (op_i == 4'd4) |-> (result_o[0] == t_i && t_o == operand_i[DW-1]));
        // R9
        t_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (op_i <= 4'd1 || op_i >= 4'd10) |-> t_o == t_i);
    end
endmodule

bind shrot_core shrot_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .operand_i (operand_i),
    .ctrl_i    (ctrl_i),
    .t_i       (t_i),
    .result_o  (result_o),
    .t_o       (t_o)
);

// File: tb/shrot_core_bench.sv
`timescale 1ns/1ps
module shrot_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [31:0] operand_i = '0;
    logic [31:0] ctrl_i = '0;
    logic        t_i = 1'b0;
    logic [31:0] result_o;
    logic        t_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shrot_core u_shrot_core (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .operand_i (operand_i),
        .ctrl_i    (ctrl_i),
        .t_i       (t_i),
        .result_o  (result_o),
        .t_o       (t_o)
    );

    // Expected {T, result} built from the requirement text
    function automatic logic [32:0] ref_model(input logic [3:0] op, input logic [31:0] a,
                                              input logic [31:0] c, input logic t);
        logic [31:0] r;
        logic        nt;
        int          n;
        r  = a;
        nt = t;
        case (op)
            4'd0, 4'd1: begin
                if (!c[31]) begin
                    r = a << c[4:0];
                end else begin
                    n = (c[4:0] == 5'd0) ? 32 : 32 - int'(c[4:0]);
                    for (int i = 0; i < n; i++) r = {(op == 4'd0) ? r[31] : 1'b0, r[31:1]};
                end
            end
            4'd2: begin r = {a[30:0], a[31]}; nt = a[31]; end
            4'd3: begin r = {a[0], a[31:1]};  nt = a[0];  end
            4'd4: begin r = {a[30:0], t};     nt = a[31]; end
            4'd5: begin r = {t, a[31:1]};     nt = a[0];  end
            4'd6, 4'd8: begin r = a << 1; nt = a[31]; end
            4'd7: begin r = {a[31], a[31:1]}; nt = a[0]; end
            4'd9: begin r = a >> 1; nt = a[0]; end
            4'd10: r = a << 2;
            4'd11: r = a >> 2;
            4'd12: r = a << 8;
            4'd13: r = a >> 8;
            4'd14: r = a << 16;
            default: r = a >> 16;
        endcase
        return {nt, r};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
        end
    endtask

    // Apply one operation, sample one clock later away from the edge
    task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] c, input logic t);
        logic [32:0] exp;
        exp = ref_model(op, a, c, t);
        @(negedge clk);
        op_i = op; operand_i = a; ctrl_i = c; t_i = t;
        @(negedge clk);
        check({tag, " value"}, result_o, exp[31:0]);
        check({tag, " T"}, {31'd0, t_o}, {31'd0, exp[32]});
    endtask

    task automatic test_reset();
        rst = 1'b1;
        op_i = 4'd2; operand_i = 32'hFFFF_FFFF; t_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset value", result_o, 32'h0);
        check("R10 reset T", {31'd0, t_o}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic test_latency();
        run_op("R10 prime", 4'd10, 32'h0000_0001, 32'h0, 1'b0);
        op_i = 4'd12; operand_i = 32'h0000_00AB;
        #1;
        check("R10 holds before edge", result_o, 32'h0000_0004);
        @(negedge clk);
        check("R10 after one clock", result_o, 32'h0000_AB00);
    endtask

    task automatic test_dyn_sweep();
        for (int op = 0; op < 2; op++) begin
            for (int code = 0; code < 64; code++) begin
                logic [31:0] c;
                logic [31:0] a;
                string tag;
                c = {code[5], 26'($urandom), code[4:0]};
                a = $urandom;
                a[31] = code[0] ^ op[0];
                if (!code[5])               tag = "R2 dyn left";
                else if (code[4:0] == 5'd0) tag = "R4 dyn full right";
                else                        tag = "R3 dyn right";
                run_op($sformatf("%s op%0d code%0d R9", tag, op, code), 4'(op), a, c, code[1]);
            end
        end
    endtask

    task automatic test_rotates();
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            a = (i == 0) ? 32'h8000_0001 : $urandom;
            run_op("R5 rotl", 4'd2, a, '0, i[0]);
            run_op("R5 rotr", 4'd3, a, '0, ~i[0]);
        end
    endtask

    task automatic test_rot_carry();
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            a = (i == 0) ? 32'h7FFF_FFFE : $urandom;
            run_op("R6 rotcl", 4'd4, a, '0, i[0]);
            run_op("R6 rotcr", 4'd5, a, '0, i[1]);
        end
    endtask

    task automatic test_single();
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            a = (i == 0) ? 32'h8000_0001 : $urandom;
            for (int op = 6; op < 10; op++)
                run_op($sformatf("R7 single op%0d", op), 4'(op), a, '0, ~a[i]);
        end
    endtask

    task automatic test_fixed();
        for (int i = 0; i < 3; i++) begin
            logic [31:0] a;
            a = (i == 0) ? 32'hC300_00A5 : $urandom;
            for (int op = 10; op < 16; op++)
                run_op($sformatf("R8 R9 R1 fixed op%0d", op), 4'(op), a, $urandom, i[0]);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_latency();
        test_dyn_sweep();
        test_rotates();
        test_rot_carry();
        test_single();
        test_fixed();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule